// File: doc/BRIEF.md
# Debug and JTAG Reset Controller

This block sits between a JTAG test access port, a debug port and the clock domains of a chip. It turns their status signals into separate reset outputs. A set of instruction codes latched in the TAP holds the functional system in reset for as long as one of them stays selected. The nTRST pin resets only the TAP logic. A debug-reset request from the debug port's control/status register resets only the resettable part of the debug domain. The core debug registers and the breakpoint unit are cleared by power-on reset alone, so they get an output of their own.

The instruction decode is registered on TCK and brought into the system clock domain through a synchronizer before it drives the system reset. Every reset output asserts asynchronously and deasserts synchronously to its own clock. Two sticky flags hold the source of the most recent system reset, either power-on or the JTAG path. Software can read each flag and clear it by writing one to it.

Top module: `dbg_rst_ctrl`

## Requirements
- R1: `sys_rst_n` is low while the latched instruction matches one of the reset codes and `tap_tlr` is low. It goes low no later than 4 `sys_clk` cycles after the TCK edge that registers the code. Default 4-bit codes: flash-programming port enable 4'hD, EXTEST 4'h0, HIGHZ 4'h9, CLAMP 4'h4.
- R2: Once any other code is latched, or `tap_tlr` is high, `sys_rst_n` returns high within 6 `sys_clk` cycles of the registering TCK edge.
- R3: The rising edge of a JTAG-caused system reset sets `src_flag_jtag` and clears `src_flag_por`. The JTAG flag stays set after the reset is released, until a write of one on `src_clr` bit 1 or a power-on reset.
- R4: While `trst_n` is low, `tap_rst_n` is low. `sys_rst_n`, `dbg_rst_n`, `core_dbg_rst_n` and both flags keep their values.
- R5: `tap_rst_n` asserts with no TCK edge. It stays low after `trst_n` rises until two TCK rising edges have occurred.
- R6: A rising `dbg_rst_req` drives `dbg_rst_n` low for exactly PULSE_CYC `dbg_clk` cycles (default 2). `dbg_rst_ack` rises in the cycle the pulse ends. `core_dbg_rst_n` is not affected.
- R7: `dbg_rst_ack` stays high while `dbg_rst_req` is high and falls one `dbg_clk` cycle after the request falls. A held request produces no second pulse.
- R8: While `por_n` is low, all four reset outputs are low, `src_flag_por` is 1 and `src_flag_jtag` is 0. Writing one on `src_clr` bit 0 clears only the power-on flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on reset, active low |
| sys_clk | input | 1 | System clock |
| tck | input | 1 | JTAG test clock, may stop |
| dbg_clk | input | 1 | Debug-domain clock |
| trst_n | input | 1 | JTAG TAP reset pin, active low |
| tap_tlr | input | 1 | TAP is in test-logic-reset |
| ir_code | input | IR_W | Latched TAP instruction |
| dbg_rst_req | input | 1 | Debug-reset request bit (dbg_clk domain) |
| src_clr | input | 2 | Write-one-to-clear strobe: bit 1 JTAG flag, bit 0 power-on flag |
| sys_rst_n | output | 1 | Functional system reset, active low |
| tap_rst_n | output | 1 | TAP/JTAG logic reset, active low |
| dbg_rst_n | output | 1 | Resettable debug-domain reset, active low |
| core_dbg_rst_n | output | 1 | Core debug and breakpoint reset, active low |
| dbg_rst_ack | output | 1 | Acknowledge of the debug-reset request |
| src_flag_por | output | 1 | Sticky: last system reset came from power-on |
| src_flag_jtag | output | 1 | Sticky: last system reset came from JTAG |

## Verification
The assertions check on every cycle the properties that hold locally. A synchronized JTAG request always holds the system in reset, and the system reset never asserts from any other source. nTRST always holds the TAP in reset. The debug pulse lasts at least two cycles and the acknowledge follows it. At most one source flag is set, and the core debug reset is never pulsed after power-on. The bench scenarios cover the rest: the full decode over all sixteen instruction codes, release after the code changes, the stopped-TCK case, the exact pulse length, and the sticky and clear behaviour of the flags across power-on and JTAG resets.

// File: rtl/dbgrst_pkg.sv
package dbgrst_pkg;
   localparam int unsigned N_RST_CODES = 4;
   localparam int unsigned N_SRC       = 2;

   typedef struct packed {
      logic jtag;
      logic por;
   } rst_src_t;
endpackage

// File: rtl/dbgrst_sync.sv
module dbgrst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("dbgrst_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain <= '0;
      else         chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dbgrst_ir_decode.sv
module dbgrst_ir_decode #(
   parameter int unsigned IR_W   = 4,
   parameter int unsigned NCODES = 4,
   parameter logic [NCODES*IR_W-1:0] CODES = '0
) (
   input  logic            tck,
   input  logic            rst_n,
   input  logic [IR_W-1:0] ir_code,
   input  logic            tap_tlr,
   output logic            hit_q
);
   logic [NCODES-1:0] hit;

   for (genvar i = 0; i < NCODES; i++) begin : g_match
      assign hit[i] = (ir_code == CODES[i*IR_W +: IR_W]);
      for (genvar j = i + 1; j < NCODES; j++) begin : g_distinct
         if (CODES[i*IR_W +: IR_W] == CODES[j*IR_W +: IR_W]) begin : g_dup
            $error("dbgrst_ir_decode: reset instruction codes must differ");
         end
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= (|hit) && !tap_tlr;
   end
endmodule

// File: rtl/dbgrst_dbg_hs.sv
module dbgrst_dbg_hs #(
   parameter int unsigned PULSE_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic pulse,
   output logic ack
);
   localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYC - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse <= 1'b0;
         ack   <= 1'b0;
         cnt   <= '0;
      end else if (pulse) begin
         cnt <= cnt + 1'b1;
         if (cnt == LAST) begin
            pulse <= 1'b0;
            ack   <= 1'b1;
         end
      end else if (ack) begin
         if (!req) ack <= 1'b0;
      end else if (req) begin
         pulse <= 1'b1;
         cnt   <= '0;
      end
   end
endmodule

// File: rtl/dbgrst_src_flags.sv
module dbgrst_src_flags
   import dbgrst_pkg::*;
(
   input  logic             clk,
   input  logic             por_n,
   input  logic             jtag_lvl,
   input  logic [N_SRC-1:0] clr,
   output rst_src_t         flags
);
   logic jtag_d;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         flags  <= '{jtag: 1'b0, por: 1'b1};
         jtag_d <= 1'b0;
      end else begin
         jtag_d <= jtag_lvl;
         if (jtag_lvl && !jtag_d) begin
            flags <= '{jtag: 1'b1, por: 1'b0};
         end else begin
            if (clr[1]) flags.jtag <= 1'b0;
            if (clr[0]) flags.por  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dbg_rst_ctrl.sv
module dbg_rst_ctrl
   import dbgrst_pkg::*;
#(
   parameter int unsigned IR_W        = 4,
   parameter logic [IR_W-1:0] IR_FLASH  = 4'hD,
   parameter logic [IR_W-1:0] IR_EXTEST = 4'h0,
   parameter logic [IR_W-1:0] IR_HIGHZ  = 4'h9,
   parameter logic [IR_W-1:0] IR_CLAMP  = 4'h4,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PULSE_CYC   = 2
) (
   input  logic            por_n,
   input  logic            sys_clk,
   input  logic            tck,
   input  logic            dbg_clk,
   input  logic            trst_n,
   input  logic            tap_tlr,
   input  logic [IR_W-1:0] ir_code,
   input  logic            dbg_rst_req,
   input  logic [1:0]      src_clr,
   output logic            sys_rst_n,
   output logic            tap_rst_n,
   output logic            dbg_rst_n,
   output logic            core_dbg_rst_n,
   output logic            dbg_rst_ack,
   output logic            src_flag_por,
   output logic            src_flag_jtag
);
   localparam logic [N_RST_CODES*IR_W-1:0] CODE_SET =
      {IR_CLAMP, IR_HIGHZ, IR_EXTEST, IR_FLASH};

   if (PULSE_CYC < 2) begin : g_bad_pulse
      $error("dbg_rst_ctrl: PULSE_CYC must be at least 2");
   end
   if (IR_W < 2) begin : g_bad_irw
      $error("dbg_rst_ctrl: IR_W must be at least 2");
   end

   logic     tap_arst_n;
   logic     jtag_hit_tck;
   logic     jtag_rst_s;
   logic     sys_arst_n;
   logic     dbg_pulse;
   rst_src_t flags;

   // TAP domain reset: pin or power-on, released on TCK
   assign tap_arst_n = trst_n & por_n;

   dbgrst_sync #(.STAGES(SYNC_STAGES)) u_tap_rst (
      .clk(tck), .arst_n(tap_arst_n), .d(1'b1), .q(tap_rst_n)
   );

   dbgrst_ir_decode #(.IR_W(IR_W), .NCODES(N_RST_CODES), .CODES(CODE_SET)) u_dec (
      .tck(tck), .rst_n(tap_rst_n), .ir_code(ir_code),
      .tap_tlr(tap_tlr), .hit_q(jtag_hit_tck)
   );

   // crossing of the registered decode into the system domain
   dbgrst_sync #(.STAGES(SYNC_STAGES)) u_jtag_cdc (
      .clk(sys_clk), .arst_n(por_n), .d(jtag_hit_tck), .q(jtag_rst_s)
   );

   assign sys_arst_n = por_n & ~jtag_rst_s;

   dbgrst_sync #(.STAGES(SYNC_STAGES)) u_sys_rst (
      .clk(sys_clk), .arst_n(sys_arst_n), .d(1'b1), .q(sys_rst_n)
   );

   dbgrst_src_flags u_flags (
      .clk(sys_clk), .por_n(por_n), .jtag_lvl(jtag_rst_s),
      .clr(src_clr), .flags(flags)
   );

   assign src_flag_por  = flags.por;
   assign src_flag_jtag = flags.jtag;

   // debug domain: power-on only for core debug, plus request pulse for the rest
   dbgrst_sync #(.STAGES(SYNC_STAGES)) u_core_dbg_rst (
      .clk(dbg_clk), .arst_n(por_n), .d(1'b1), .q(core_dbg_rst_n)
   );

   dbgrst_dbg_hs #(.PULSE_CYC(PULSE_CYC)) u_hs (
      .clk(dbg_clk), .rst_n(por_n), .req(dbg_rst_req),
      .pulse(dbg_pulse), .ack(dbg_rst_ack)
   );

   assign dbg_rst_n = core_dbg_rst_n & ~dbg_pulse;
endmodule

// File: rtl/dbg_rst_ctrl_chk.sv
module dbg_rst_ctrl_chk (
   input logic por_n,
   input logic sys_clk,
   input logic dbg_clk,
   input logic trst_n,
   input logic jtag_rst_s,
   input logic sys_rst_n,
   input logic tap_rst_n,
   input logic dbg_rst_n,
   input logic core_dbg_rst_n,
   input logic dbg_rst_req,
   input logic dbg_rst_ack,
   input logic src_flag_por,
   input logic src_flag_jtag
);
   // R1: synchronized JTAG request holds the system in reset
   p_sys_held_r1: assert property (@(posedge sys_clk) disable iff (!por_n)
      jtag_rst_s |-> !sys_rst_n);

   // R4: system reset asserts from no source but the JTAG path
   p_sys_only_jtag_r4: assert property (@(posedge sys_clk) disable iff (!por_n)
      (!jtag_rst_s && $past(sys_rst_n)) |-> sys_rst_n);

   // R5: nTRST low always holds the TAP in reset
   p_tap_pin_r5: assert property (@(posedge sys_clk) disable iff (!por_n)
      !trst_n |-> !tap_rst_n);

   // R6: debug pulse lasts at least two cycles
   p_pulse_min_r6: assert property (@(posedge dbg_clk) disable iff (!por_n)
      $fell(dbg_rst_n) |=> !dbg_rst_n);

   // R6: acknowledge rises only as the pulse ends
   p_ack_after_r6: assert property (@(posedge dbg_clk) disable iff (!por_n)
      $rose(dbg_rst_ack) |-> (dbg_rst_n && !$past(dbg_rst_n)));

   // R7: acknowledge drops after the request is withdrawn
   p_ack_drop_r7: assert property (@(posedge dbg_clk) disable iff (!por_n)
      (dbg_rst_ack && !dbg_rst_req) |=> !dbg_rst_ack);

   // R6: core debug reset never pulses after power-on
   p_core_dbg_kept_r6: assert property (@(posedge dbg_clk) disable iff (!por_n)
      $past(core_dbg_rst_n) |-> core_dbg_rst_n);

   // R3: at most one source flag is set
   p_one_src_r3: assert property (@(posedge sys_clk) disable iff (!por_n)
      $onehot0({src_flag_por, src_flag_jtag}));
endmodule

bind dbg_rst_ctrl dbg_rst_ctrl_chk u_chk (
   .por_n(por_n), .sys_clk(sys_clk), .dbg_clk(dbg_clk), .trst_n(trst_n),
   .jtag_rst_s(jtag_rst_s), .sys_rst_n(sys_rst_n), .tap_rst_n(tap_rst_n),
   .dbg_rst_n(dbg_rst_n), .core_dbg_rst_n(core_dbg_rst_n),
   .dbg_rst_req(dbg_rst_req), .dbg_rst_ack(dbg_rst_ack),
   .src_flag_por(src_flag_por), .src_flag_jtag(src_flag_jtag)
);

// File: tb/dbg_rst_ctrl_test.sv
module dbg_rst_ctrl_test;
   logic       por_n = 1'b0;
   logic       sys_clk = 1'b0;
   logic       tck = 1'b0;
   logic       tck_en = 1'b1;
   logic       dbg_clk = 1'b0;
   logic       trst_n = 1'b1;
   logic       tap_tlr = 1'b0;
   logic [3:0] ir_code = 4'h1;
   logic       dbg_rst_req = 1'b0;
   logic [1:0] src_clr = 2'b00;
   logic       sys_rst_n, tap_rst_n, dbg_rst_n, core_dbg_rst_n;
   logic       dbg_rst_ack, src_flag_por, src_flag_jtag;

   int checks = 0;
   int failures = 0;

   always #10 sys_clk = ~sys_clk;
   always #20 tck = tck_en ? ~tck : 1'b0;
   always #15 dbg_clk = ~dbg_clk;

   dbg_rst_ctrl uut (
      .por_n(por_n), .sys_clk(sys_clk), .tck(tck), .dbg_clk(dbg_clk),
      .trst_n(trst_n), .tap_tlr(tap_tlr), .ir_code(ir_code),
      .dbg_rst_req(dbg_rst_req), .src_clr(src_clr),
      .sys_rst_n(sys_rst_n), .tap_rst_n(tap_rst_n), .dbg_rst_n(dbg_rst_n),
      .core_dbg_rst_n(core_dbg_rst_n), .dbg_rst_ack(dbg_rst_ack),
      .src_flag_por(src_flag_por), .src_flag_jtag(src_flag_jtag)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b", req, act, exp);
      end
   endtask

   function automatic logic is_rst_code(input logic [3:0] c);
      return (c == 4'hD) || (c == 4'h0) || (c == 4'h9) || (c == 4'h4);
   endfunction

   task automatic tck_wait(input int n);
      for (int i = 0; i < n; i++) @(negedge tck);
   endtask

   task automatic sys_wait(input int n);
      for (int i = 0; i < n; i++) @(negedge sys_clk);
   endtask

   task automatic clr_pulse(input logic [1:0] v);
      @(negedge sys_clk);
      src_clr = v;
      @(negedge sys_clk);
      src_clr = 2'b00;
      @(negedge sys_clk);
   endtask

   task automatic dbg_handshake();
      int low = 0;
      logic core_ok = 1'b1;
      logic other_ok = 1'b1;
      @(negedge dbg_clk);
      dbg_rst_req = 1'b1;
      for (int i = 0; i < 10; i++) begin
         @(negedge dbg_clk);
         if (!dbg_rst_n) low++;
         if (!core_dbg_rst_n) core_ok = 1'b0;
         if (!sys_rst_n || !tap_rst_n) other_ok = 1'b0;
      end
      checks++;
      if (low != 2) begin
         failures++;
         $display("FAIL R6 pulse length actual=%0d expected=2", low);
      end
      chk("R6 core debug reset untouched", core_ok, 1'b1);
      chk("R6 sys/tap untouched by debug request", other_ok, 1'b1);
      chk("R7 ack held while request high", dbg_rst_ack, 1'b1);
      dbg_rst_req = 1'b0;
      @(negedge dbg_clk);
      chk("R7 ack falls after request low", dbg_rst_ack, 1'b0);
   endtask

   initial begin
      #2000000;
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R8: power-on state
      sys_wait(3);
      chk("R8 sys_rst_n in por", sys_rst_n, 1'b0);
      chk("R8 tap_rst_n in por", tap_rst_n, 1'b0);
      chk("R8 dbg_rst_n in por", dbg_rst_n, 1'b0);
      chk("R8 core_dbg_rst_n in por", core_dbg_rst_n, 1'b0);
      chk("R8 por flag in por", src_flag_por, 1'b1);
      chk("R8 jtag flag in por", src_flag_jtag, 1'b0);
      @(negedge sys_clk);
      por_n = 1'b1;
      tck_wait(6);
      chk("R8 sys released", sys_rst_n, 1'b1);
      chk("R8 tap released", tap_rst_n, 1'b1);
      chk("R8 dbg released", dbg_rst_n, 1'b1);
      chk("R8 core dbg released", core_dbg_rst_n, 1'b1);
      chk("R8 por flag sticky", src_flag_por, 1'b1);

      // R1 R2: sweep every instruction code, then a release code
      for (int c = 0; c < 16; c++) begin
         @(negedge tck);
         ir_code = 4'(c);
         tck_wait(6);
         chk($sformatf("R1 decode code %0h", c), sys_rst_n, !is_rst_code(4'(c)));
         if (c == 0) begin
            chk("R3 jtag flag set", src_flag_jtag, 1'b1);
            chk("R3 por flag cleared by jtag", src_flag_por, 1'b0);
         end
         @(negedge tck);
         ir_code = 4'h1;
         tck_wait(4);
         chk($sformatf("R2 release after code %0h", c), sys_rst_n, 1'b1);
      end
      chk("R3 jtag flag sticky after release", src_flag_jtag, 1'b1);
      clr_pulse(2'b01);
      chk("R8 por clear leaves jtag flag", src_flag_jtag, 1'b1);
      clr_pulse(2'b10);
      chk("R3 jtag flag cleared by write", src_flag_jtag, 1'b0);

      // R2: test-logic-reset drops the decode
      @(negedge tck);
      ir_code = 4'h9;
      tck_wait(6);
      chk("R1 HIGHZ asserts", sys_rst_n, 1'b0);
      tap_tlr = 1'b1;
      tck_wait(4);
      chk("R2 release in test-logic-reset", sys_rst_n, 1'b1);
      tap_tlr = 1'b0;
      ir_code = 4'h1;
      tck_wait(4);
      clr_pulse(2'b10);

      // R4: nTRST touches only the TAP
      @(negedge tck);
      trst_n = 1'b0;
      tck_wait(4);
      chk("R4 tap reset on pin", tap_rst_n, 1'b0);
      chk("R4 no system reset", sys_rst_n, 1'b1);
      chk("R4 no debug reset", dbg_rst_n, 1'b1);
      chk("R4 no core debug reset", core_dbg_rst_n, 1'b1);
      chk("R4 jtag flag unchanged", src_flag_jtag, 1'b0);
      chk("R4 por flag unchanged", src_flag_por, 1'b0);
      trst_n = 1'b1;
      tck_wait(4);
      chk("R5 tap released with tck", tap_rst_n, 1'b1);

      // R5: TCK stopped
      tck_en = 1'b0;
      #100;
      trst_n = 1'b0;
      #5;
      chk("R5 tap reset without tck", tap_rst_n, 1'b0);
      #50;
      trst_n = 1'b1;
      #200;
      chk("R5 tap held until tck runs", tap_rst_n, 1'b0);
      tck_en = 1'b1;
      tck_wait(4);
      chk("R5 tap released after tck edges", tap_rst_n, 1'b1);

      // R6 R7: debug handshake twice
      dbg_handshake();
      dbg_handshake();

      // R8: power-on replaces jtag flag
      @(negedge tck);
      ir_code = 4'h4;
      tck_wait(6);
      chk("R3 CLAMP sets jtag flag", src_flag_jtag, 1'b1);
      ir_code = 4'h1;
      tck_wait(4);
      @(negedge sys_clk);
      por_n = 1'b0;
      sys_wait(2);
      chk("R8 por sets por flag", src_flag_por, 1'b1);
      chk("R8 por clears jtag flag", src_flag_jtag, 1'b0);
      por_n = 1'b1;
      tck_wait(6);
      clr_pulse(2'b01);
      chk("R8 por flag cleared by write", src_flag_por, 1'b0);
      chk("R8 system running", sys_rst_n, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule